// File: doc/BRIEF.md
# Single-Channel DMA Controller with Reload

This block moves data one unit at a time between two locations in a byte-addressed memory. Software programs a source pointer, a destination pointer and a transfer count through a small register window. It then picks one of sixteen external request lines and enables the channel. Each rising edge on the chosen line latches a request flag. While the channel is enabled, a pending flag launches one unit transfer: a read from the source pointer, then a write of that data to the destination pointer.

Each pointer can be held fixed or stepped forward by the unit size, either one byte or one 16-bit word. The live counter drops by one per unit. When it runs out, the channel turns itself off and pulses a completion output for one cycle. Any control write that sets the enable bit acts as a restart, including one made while the channel is running. It reloads the forward-stepping pointers from their programmed values and reloads the counter from its reload register.

Top module: `dma_chan`

## Requirements
- R1: After reset every readable register reads 0, no memory read or write is driven and `done` is low.
- R2: The control register sits at register address 0. Its bits are: bit 0 unit size (1 = 16-bit), bit 2 request flag, bit 3 enable, bit 4 source forward, bit 5 destination forward, bits 11:8 request select. All other bits read 0. The enable bit reads 1 while the channel is active.
- R3: A rising edge on `req_in[select]` sets the request flag, whether or not the channel is enabled.
- R4: The request flag clears in the cycle a unit transfer starts. A control write loads the flag from bit 2 of the written data, so writing 0 clears it.
- R5: Changing the select field to an input that is already high sets the request flag.
- R6: A unit transfer is one cycle with `mem_rd` high at the source address, followed by one cycle with `mem_wr` high at the destination address. `mem_wdata` carries the `mem_rdata` returned in that write cycle. The read and write strobes are never high together.
- R7: After each unit, a forward pointer grows by 1 for byte units or by 2 for word units. A fixed pointer keeps its value.
- R8: The live counter drops by 1 per unit. The unit that takes it from 1 to 0 clears the enable bit and raises `done` for exactly one cycle, in the cycle after that unit's write.
- R9: A control write with bit 3 set reloads each pointer marked forward in the written data from its programmed value, and reloads the counter from the reload register. This applies even while the channel is active, and the channel restarts idle.
- R10: A control write with bit 3 clear stops the channel at once. No transfer starts while the enable bit is 0.
- R11: Register address 1 is the source pointer and address 2 is the destination pointer. A write to either sets both its programmed value and its live value, and a read returns the live value. Address 3 writes the count reload register and reads the live counter, which loads only on an enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational on reg_addr) |
| req_in | input | 2**SELW | External transfer request lines |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_size16 | output | 1 | Unit size: 1 = 16-bit, 0 = byte |
| mem_addr | output | W | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after mem_rd |
| done | output | 1 | One-cycle pulse when the counter runs out |

## Verification
The assertions check, on every cycle, the rules that hold from one step to the next:
- the read and write strobes never overlap;
- a read is followed by its write unless a control write intervenes;
- the counter drops by exactly one per write;
- a fixed source pointer stays put;
- `done` lasts one cycle and leaves the channel disabled;
- nothing starts while the channel is off.

Only the bench scenarios can show the rest:
- data lands at the right bytes for each pointer mode and unit size;
- requests latch while disabled and clear when a transfer starts;
- a select change raises a spurious request;
- a mid-run enable write puts the pointer and counter back to their programmed values.

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int W    = 16,
  parameter int SELW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [1:0]            reg_addr,
  input  logic [W-1:0]          reg_wdata,
  output logic [W-1:0]          reg_rdata,
  input  logic [(1<<SELW)-1:0]  req_in,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  mem_size16,
  output logic [W-1:0]          mem_addr,
  output logic [15:0]           mem_wdata,
  input  logic [15:0]           mem_rdata,
  output logic                  done
);
  localparam int B_SIZE = 0;
  localparam int B_REQ  = 2;
  localparam int B_EN   = 3;
  localparam int B_SFWD = 4;
  localparam int B_DFWD = 5;
  localparam int B_SEL  = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_t;
  st_t st;

  logic size16_q, sfwd_q, dfwd_q, req_q, en_q, prev_q, done_q;
  logic [SELW-1:0] sel_q;
  logic [W-1:0] src_base, dst_base, src_ptr, dst_ptr, cnt_base, cnt;
  logic [W-1:0] ctl_rd;

  wire ctl_wr  = reg_we && reg_addr == 2'd0;
  wire sel_now = req_in[sel_q];
  wire rise    = sel_now & ~prev_q;
  wire start   = (st == ST_IDLE) && en_q && req_q && !ctl_wr;
  wire last    = cnt == W'(1);
  wire [W-1:0] step = size16_q ? W'(2) : W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      size16_q <= 1'b0;
      sfwd_q   <= 1'b0;
      dfwd_q   <= 1'b0;
      req_q    <= 1'b0;
      en_q     <= 1'b0;
      prev_q   <= 1'b0;
      done_q   <= 1'b0;
      sel_q    <= '0;
      src_base <= '0;
      dst_base <= '0;
      src_ptr  <= '0;
      dst_ptr  <= '0;
      cnt_base <= '0;
      cnt      <= '0;
    end else begin
      prev_q <= sel_now;
      done_q <= 1'b0;

      if (ctl_wr)     req_q <= reg_wdata[B_REQ] | rise;
      else if (start) req_q <= rise;
      else if (rise)  req_q <= 1'b1;

      if (ctl_wr) begin
        size16_q <= reg_wdata[B_SIZE];
        sfwd_q   <= reg_wdata[B_SFWD];
        dfwd_q   <= reg_wdata[B_DFWD];
        sel_q    <= reg_wdata[B_SEL +: SELW];
        en_q     <= reg_wdata[B_EN];
        st       <= ST_IDLE;
        if (reg_wdata[B_EN]) begin
          if (reg_wdata[B_SFWD]) src_ptr <= src_base;
          if (reg_wdata[B_DFWD]) dst_ptr <= dst_base;
          cnt <= cnt_base;
        end
      end else begin
        case (st)
          ST_IDLE: if (start) st <= ST_RD;
          ST_RD:   st <= ST_WR;
          ST_WR: begin
            st <= ST_IDLE;
            if (sfwd_q) src_ptr <= src_ptr + step;
            if (dfwd_q) dst_ptr <= dst_ptr + step;
            cnt <= cnt - W'(1);
            if (last) begin
              en_q   <= 1'b0;
              done_q <= 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end

      if (reg_we && reg_addr == 2'd1) begin
        src_base <= reg_wdata;
        src_ptr  <= reg_wdata;
      end
      if (reg_we && reg_addr == 2'd2) begin
        dst_base <= reg_wdata;
        dst_ptr  <= reg_wdata;
      end
      if (reg_we && reg_addr == 2'd3) cnt_base <= reg_wdata;
    end
  end

  always_comb begin
    ctl_rd = '0;
    ctl_rd[B_SIZE] = size16_q;
    ctl_rd[B_REQ]  = req_q;
    ctl_rd[B_EN]   = en_q;
    ctl_rd[B_SFWD] = sfwd_q;
    ctl_rd[B_DFWD] = dfwd_q;
    ctl_rd[B_SEL +: SELW] = sel_q;
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctl_rd;
      2'd1:    reg_rdata = src_ptr;
      2'd2:    reg_rdata = dst_ptr;
      default: reg_rdata = cnt;
    endcase
  end

  assign mem_rd     = st == ST_RD;
  assign mem_wr     = st == ST_WR;
  assign mem_addr   = (st == ST_WR) ? dst_ptr : src_ptr;
  assign mem_wdata  = mem_rdata;
  assign mem_size16 = size16_q;
  assign done       = done_q;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic         mem_rd,
  input logic         mem_wr,
  input logic         done,
  input logic         en,
  input logic         sfwd,
  input logic [W-1:0] sptr,
  input logic [W-1:0] cnt
);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));

  // R6
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !reg_we |=> mem_wr);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !en);

  // R8
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && !reg_we |=> cnt == $past(cnt) - W'(1));

  // R7
  fixed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && !sfwd && !reg_we |=> $stable(sptr));

  // R10
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !reg_we |=> !mem_rd);
endmodule

bind dma_chan dma_chan_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .reg_we (reg_we),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .done   (done),
  .en     (en_q),
  .sfwd   (sfwd_q),
  .sptr   (src_ptr),
  .cnt    (cnt)
);

// File: tb/dma_chan_tb_top.sv
module dma_chan_tb_top;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [15:0] req_in = '0;
  logic        mem_rd, mem_wr, mem_size16, done;
  logic [W-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  dma_chan #(.W(W), .SELW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_size16(mem_size16),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done)
  );

  always #10 clk = ~clk;

  logic [7:0] mem_b [256];
  logic [7:0] exp_b [256];
  int checks = 0, fails = 0, cyc = 0, rd_cnt = 0, done_cnt = 0;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= {mem_b[mem_addr[7:0] + 8'd1], mem_b[mem_addr[7:0]]};
    if (mem_wr) begin
      mem_b[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_size16) mem_b[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
    end
    if (rst_n) begin
      if (mem_rd) rd_cnt++;
      if (done) done_cnt++;
    end
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired: act=%0d cycles exp<=100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); req_in[idx] = 1'b1;
    @(negedge clk); req_in[idx] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [W-1:0] mkctl(input logic [3:0] sel, input logic dfwd,
      input logic sfwd, input logic en, input logic req, input logic sz);
    return {4'b0, sel, 2'b0, dfwd, sfwd, en, req, 1'b0, sz};
  endfunction

  // {size16, src fwd, dst fwd, count[3:0], src[7:0], dst[7:0]}
  localparam logic [22:0] VEC [6] = '{
    {1'b0, 1'b1, 1'b1, 4'd4, 8'h10, 8'h80},
    {1'b1, 1'b1, 1'b1, 4'd3, 8'h20, 8'h90},
    {1'b0, 1'b0, 1'b1, 4'd3, 8'h30, 8'hA0},
    {1'b1, 1'b1, 1'b0, 4'd2, 8'h40, 8'hB0},
    {1'b0, 1'b1, 1'b0, 4'd5, 8'h50, 8'hC0},
    {1'b1, 1'b0, 1'b1, 4'd1, 8'h60, 8'hD0}
  };

  initial begin
    logic [W-1:0] d;
    int r0, d0;
    for (int i = 0; i < 256; i++) mem_b[i] = 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 register reads 0 after reset", d, 0);
    end
    chk("R1 no strobes or done after reset", {mem_rd, mem_wr, done}, 0);

    // R11 pointer readback, counter not loaded by reload write
    wr(2'd1, 16'h1234);
    rd(2'd1, d);
    chk("R11 source pointer readback", d, 16'h1234);
    wr(2'd3, 16'd7);
    rd(2'd3, d);
    chk("R11 live counter untouched by reload write", d, 0);

    // R3 request latches while disabled
    r0 = rd_cnt;
    wr(2'd0, mkctl(4'd3, 0, 0, 0, 0, 0));
    pulse(3);
    rd(2'd0, d);
    chk("R3 request bit set while disabled", d[2], 1);
    chk("R10 no transfer while disabled", rd_cnt - r0, 0);

    // R4 software clear
    wr(2'd0, mkctl(4'd3, 0, 0, 0, 0, 0));
    rd(2'd0, d);
    chk("R4 request bit cleared by writing 0", d[2], 0);

    // R5 spurious set on select change
    @(negedge clk); req_in[9] = 1'b1;
    repeat (2) @(negedge clk);
    wr(2'd0, mkctl(4'd9, 0, 0, 0, 0, 0));
    @(negedge clk);
    rd(2'd0, d);
    chk("R5 select change sets request", d[2], 1);
    wr(2'd0, mkctl(4'd9, 0, 0, 0, 0, 0));
    @(negedge clk);
    rd(2'd0, d);
    chk("R5 same select with high input stays clear", d[2], 0);
    req_in[9] = 1'b0;

    // R4 pending request starts transfer on enable, flag clears
    wr(2'd1, 16'h0008);
    wr(2'd2, 16'h0070);
    wr(2'd3, 16'd1);
    wr(2'd0, mkctl(4'd3, 0, 0, 0, 0, 0));
    pulse(3);
    r0 = rd_cnt; d0 = done_cnt;
    wr(2'd0, mkctl(4'd3, 1, 1, 1, 1, 0));
    repeat (8) @(negedge clk);
    chk("R4 pending request launched one transfer", rd_cnt - r0, 1);
    rd(2'd0, d);
    chk("R4 request bit clear after start", d[2], 0);
    chk("R8 enable cleared after count ran out", d[3], 0);
    chk("R8 one done pulse", done_cnt - d0, 1);

    // R9 restart while active
    wr(2'd1, 16'h0010);
    wr(2'd2, 16'h0080);
    wr(2'd3, 16'd4);
    wr(2'd0, mkctl(4'd3, 1, 1, 1, 0, 0));
    rd(2'd0, d);
    chk("R2 enable bit reads 1 while active", d[3], 1);
    pulse(3);
    pulse(3);
    rd(2'd1, d);
    chk("R7 source stepped by 2 bytes", d, 16'h0012);
    rd(2'd3, d);
    chk("R8 counter after two units", d, 2);
    wr(2'd0, mkctl(4'd3, 1, 1, 1, 0, 0));
    rd(2'd1, d);
    chk("R9 source reloaded on restart", d, 16'h0010);
    rd(2'd2, d);
    chk("R9 destination reloaded on restart", d, 16'h0080);
    rd(2'd3, d);
    chk("R9 counter reloaded on restart", d, 4);
    r0 = rd_cnt; d0 = done_cnt;
    for (int k = 0; k < 4; k++) pulse(3);
    chk("R9 restarted run does full count", rd_cnt - r0, 4);
    chk("R8 single done after restarted run", done_cnt - d0, 1);

    // R10 disable stops channel
    wr(2'd3, 16'd4);
    wr(2'd0, mkctl(4'd3, 1, 1, 1, 0, 0));
    wr(2'd0, mkctl(4'd3, 1, 1, 0, 0, 0));
    r0 = rd_cnt;
    pulse(3);
    chk("R10 no transfer after disable", rd_cnt - r0, 0);
    rd(2'd0, d);
    chk("R3 request latched while disabled", d[2], 1);

    // Vector table: R6 R7 R8
    foreach (VEC[v]) begin
      logic sz, sf, df;
      int n, sa, da, inc;
      {sz, sf, df} = VEC[v][22:20];
      n = int'(VEC[v][19:16]);
      sa = int'(VEC[v][15:8]);
      da = int'(VEC[v][7:0]);
      inc = sz ? 2 : 1;
      for (int i = 0; i < 256; i++) begin
        mem_b[i] = 8'(i * 3 + v);
        exp_b[i] = 8'(i * 3 + v);
      end
      for (int k = 0; k < n; k++) begin
        int s, t;
        logic [7:0] lo, hi;
        s = sf ? sa + k * inc : sa;
        t = df ? da + k * inc : da;
        lo = exp_b[s[7:0]];
        hi = exp_b[8'(s + 1)];
        exp_b[t[7:0]] = lo;
        if (sz) exp_b[8'(t + 1)] = hi;
      end
      wr(2'd1, W'(sa));
      wr(2'd2, W'(da));
      wr(2'd3, W'(n));
      r0 = rd_cnt; d0 = done_cnt;
      wr(2'd0, mkctl(4'd2, df, sf, 1, 0, sz));
      for (int k = 0; k < n; k++) pulse(2);
      begin
        int bad = 0;
        for (int i = 0; i < 256; i++) if (mem_b[i] !== exp_b[i]) bad++;
        chk("R6 memory contents after run", bad, 0);
      end
      chk("R6 one read per unit", rd_cnt - r0, n);
      chk("R8 one done per run", done_cnt - d0, 1);
      rd(2'd1, d);
      chk("R7 final source pointer", d, W'(sf ? sa + n * inc : sa));
      rd(2'd2, d);
      chk("R7 final destination pointer", d, W'(df ? da + n * inc : da));
      rd(2'd3, d);
      chk("R8 counter at zero", d, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule